// File: doc/BRIEF.md
# Hardware Sine Sequence Generator

This block produces 12-bit sample codes that trace one sine period in sixteen equal phase steps, for use as the data source of a two-channel DAC. While it is active, its codes replace the values that would otherwise come from the channel data registers. The analog stage and the timer that produces trigger pulses sit outside the block.

The block has two operating styles. In stepped mode, each one-cycle trigger pulse moves the wave forward by one table step, so an external timer sets the frequency. In free-running mode, the block issues its own samples at a fixed rate set by a prescaler. In this mode one gate line switches the wave on and off, and a second gate line switches the output driver. When the wave is gated off, the block holds mid-scale and returns the phase to 0 degrees. When the differential option is set, channel 1 carries the inverted wave.

Top module: `sine_seq_gen`

## Requirements
- R1: After reset, both channel codes are 2048, both convert strobes are 0, the driver enable is 0 and the phase index is 0.
- R2: In stepped mode (`free_run`=0), a one-cycle `trig` pulse updates `ch0_code` one cycle later with the table entry at the current phase and pulses `conv_stb[0]` for that cycle. The phase then advances by one. With no pulse, the code holds and no strobe appears.
- R3: Table entry k (k = 0..15) is round(2048 + 2047*sin(2*pi*k/16)) as an unsigned 12-bit code. The phase wraps from 15 back to 0.
- R4: In free-running mode with `gate_sine` high, the block issues one sample strobe every 2*(`presc`+1) clock cycles, where `presc` is an unsigned 3-bit value. The first sample appears one cycle after `gate_sine` is seen high.
- R5: In free-running mode with `gate_sine` low, `ch0_code` is 2048 one cycle later, no strobes are issued and the phase is forced to 0. After the gate rises, the first sample is entry 0 and the second is entry 1.
- R6: With `diff_en`=1, channel 1 follows channel 0 on the same step with code 4095 minus the entry and pulses `conv_stb[1]` together with `conv_stb[0]`. While the wave is gated off, `ch1_code` is 2047.
- R7: In free-running mode, `drv_oe` equals `gate_drv` as sampled one cycle earlier (0 means the output is tristated). In stepped mode, `drv_oe` is 1 one cycle after the mode is selected.
- R8: A channel whose enable is low keeps its code and gives no strobe, but the shared phase still advances on each step. With `diff_en`=0, channel 1 is never updated.
- R9: In free-running mode, `trig` has no effect: a pulse while the wave is gated off leaves `ch0_code` at 2048, produces no strobe and does not move the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| free_run | input | 1 | 1: self-timed mode with gate lines; 0: stepped by `trig` |
| diff_en | input | 1 | Inverted copy on channel 1 |
| ch0_en | input | 1 | Channel 0 enable |
| ch1_en | input | 1 | Channel 1 enable |
| presc | input | PW | Prescaler setting for the free-running rate |
| trig | input | 1 | One-cycle step pulse (stepped mode) |
| gate_sine | input | 1 | Wave gate (free-running mode) |
| gate_drv | input | 1 | Output driver gate (free-running mode) |
| ch0_code | output | 12 | Channel 0 sample code |
| ch1_code | output | 12 | Channel 1 sample code |
| conv_stb | output | 2 | Per-channel convert strobe |
| drv_oe | output | 1 | Output driver enable (0 = tristate) |

## Verification
The bench builds the block with its default 3-bit prescaler width. This makes every rate setting reachable, from the 2-cycle sample spacing at setting 0 to the 16-cycle spacing at setting 7. Three settings, including both extremes, are measured strobe to strobe. The stepped runs go past sixteen pulses, so the phase wrap and all sixteen table entries are compared with values that the bench derives from the sine formula.

// File: rtl/sine_seq_pkg.sv
`timescale 1ns/1ps
package sine_seq_pkg;
  localparam int DW = 12;
  localparam int IW = 4;
  localparam logic [DW-1:0] FULL    = '1;
  localparam logic [DW-1:0] MID     = 12'd2048;
  localparam logic [DW-1:0] MID_INV = FULL - MID;

  // Peak offset from mid-scale for a phase folded into the first quarter.
  function automatic logic [DW-1:0] quarter_amp(input logic [2:0] k);
    case (k)
      3'd0:    quarter_amp = 12'd0;
      3'd1:    quarter_amp = 12'd783;
      3'd2:    quarter_amp = 12'd1447;
      3'd3:    quarter_amp = 12'd1891;
      default: quarter_amp = 12'd2047;
    endcase
  endfunction

  // Full-period code rebuilt from quarter-wave symmetry.
  function automatic logic [DW-1:0] sine_code(input logic [IW-1:0] idx);
    logic [2:0] fold;
    fold = (idx[2:0] <= 3'd4) ? idx[2:0] : (3'd0 - idx[2:0]);
    sine_code = idx[3] ? (MID - quarter_amp(fold)) : (MID + quarter_amp(fold));
  endfunction

  function automatic logic [DW-1:0] invert_code(input logic [DW-1:0] c);
    invert_code = FULL - c;
  endfunction

  // Clock cycles between self-timed samples.
  function automatic int unsigned step_period(input int unsigned presc);
    step_period = 2 * (presc + 1);
  endfunction
endpackage

// File: rtl/sine_phase_ctrl.sv
`timescale 1ns/1ps
module sine_phase_ctrl
  import sine_seq_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          free_run,
  input  logic          gate_sine,
  input  logic          trig,
  input  logic [PW-1:0] presc,
  output logic [IW-1:0] idx,
  output logic          step,
  output logic          gated_off
);
  localparam int CW = PW + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;

  always_comb begin
    last_cnt  = CW'(step_period(int'(presc)) - 1);
    gated_off = free_run & ~gate_sine;
    step      = free_run ? (gate_sine && (cnt == '0)) : trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!free_run || gated_off) begin
      cnt <= '0;
    end else if (cnt >= last_cnt) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx <= '0;
    else if (gated_off) idx <= '0;
    else if (step)      idx <= idx + 1'b1;
  end

  AST_PHASE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    gated_off |=> (idx == '0)); // R5
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !gated_off) |=> (idx == $past(idx) + 1'b1)); // R2
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !gated_off) |=> $stable(idx)); // R2
  AST_FREE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && step) |=> !(free_run && step)); // R4
endmodule

// File: rtl/sine_chan_out.sv
`timescale 1ns/1ps
module sine_chan_out
  import sine_seq_pkg::*;
#(
  parameter bit INVERT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          active,
  input  logic          gated_off,
  input  logic          step,
  input  logic [DW-1:0] sample,
  output logic [DW-1:0] code,
  output logic          stb
);
  localparam logic [DW-1:0] HOLD_CODE = INVERT ? MID_INV : MID;

  logic          upd;
  logic [DW-1:0] next_sample;

  always_comb begin
    upd         = en & active;
    next_sample = INVERT ? invert_code(sample) : sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= MID;
      stb  <= 1'b0;
    end else begin
      stb <= upd & step & ~gated_off;
      if (upd && gated_off)  code <= HOLD_CODE;
      else if (upd && step)  code <= next_sample;
    end
  end

  AST_GATED_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_off && en && active) |=> (code == HOLD_CODE)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && active) |=> ($stable(code) && !stb)); // R8
endmodule

// File: rtl/sine_seq_gen.sv
`timescale 1ns/1ps
module sine_seq_gen
  import sine_seq_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          free_run,
  input  logic          diff_en,
  input  logic          ch0_en,
  input  logic          ch1_en,
  input  logic [PW-1:0] presc,
  input  logic          trig,
  input  logic          gate_sine,
  input  logic          gate_drv,
  output logic [11:0]   ch0_code,
  output logic [11:0]   ch1_code,
  output logic [1:0]    conv_stb,
  output logic          drv_oe
);
  localparam int NCH = 2;

  logic [IW-1:0]  idx;
  logic           step;
  logic           gated_off;
  logic [DW-1:0]  sample;
  logic [NCH-1:0] chan_en;
  logic [NCH-1:0] chan_act;
  logic [DW-1:0]  codes [NCH];

  assign chan_en  = {ch1_en, ch0_en};
  assign chan_act = {diff_en, 1'b1};
  assign sample   = sine_code(idx);

  sine_phase_ctrl #(.PW(PW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .free_run  (free_run),
    .gate_sine (gate_sine),
    .trig      (trig),
    .presc     (presc),
    .idx       (idx),
    .step      (step),
    .gated_off (gated_off)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    sine_chan_out #(.INVERT(g == 1)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (chan_en[g]),
      .active    (chan_act[g]),
      .gated_off (gated_off),
      .step      (step),
      .sample    (sample),
      .code      (codes[g]),
      .stb       (conv_stb[g])
    );
  end

  assign ch0_code = codes[0];
  assign ch1_code = codes[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_oe <= 1'b0;
    else        drv_oe <= free_run ? gate_drv : 1'b1;
  end

  AST_DRV_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    free_run |=> (drv_oe == $past(gate_drv))); // R7
  AST_DIFF_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_stb == 2'b11) |-> ({1'b0, ch0_code} + {1'b0, ch1_code} == 13'd4095)); // R6
  AST_STB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_stb[0] |-> $past(ch0_en)); // R8
endmodule

// File: tb/sine_seq_gen_test.sv
`timescale 1ns/1ps
module sine_seq_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        free_run = 1'b0, diff_en = 1'b0, ch0_en = 1'b1, ch1_en = 1'b0;
  logic [2:0]  presc = 3'd0;
  logic        trig = 1'b0, gate_sine = 1'b0, gate_drv = 1'b0;
  logic [11:0] ch0_code, ch1_code;
  logic [1:0]  conv_stb;
  logic        drv_oe;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sine_seq_gen uut (
    .clk(clk), .rst_n(rst_n), .free_run(free_run), .diff_en(diff_en),
    .ch0_en(ch0_en), .ch1_en(ch1_en), .presc(presc), .trig(trig),
    .gate_sine(gate_sine), .gate_drv(gate_drv), .ch0_code(ch0_code),
    .ch1_code(ch1_code), .conv_stb(conv_stb), .drv_oe(drv_oe)
  );

  function automatic int tab(int k);
    real v;
    v = 2048.0 + 2047.0 * $sin(2.0 * 3.14159265358979 * (k % 16) / 16.0);
    return int'($floor(v + 0.5));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    tick();
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ch0_code", ch0_code, 2048);
    chk("R1 ch1_code", ch1_code, 2048);
    chk("R1 conv_stb", conv_stb, 0);
    chk("R1 drv_oe", drv_oe, 0);
  endtask

  task automatic t_stepped();
    @(negedge clk) begin free_run = 1'b0; diff_en = 1'b0; ch0_en = 1'b1; end
    tick();
    chk("R7 stepped drv_oe", drv_oe, 1);
    for (int n = 0; n < 18; n++) begin
      @(negedge clk) trig = 1'b1;
      tick();
      chk("R3 table entry", ch0_code, tab(ph));
      chk("R2 strobe", conv_stb[0], 1);
      ph = (ph + 1) % 16;
      @(negedge clk) trig = 1'b0;
    end
    for (int n = 0; n < 3; n++) begin
      tick();
      chk("R2 hold code", ch0_code, tab(ph + 15));
      chk("R2 no strobe", conv_stb, 0);
    end
  endtask

  task automatic t_disable();
    int held;
    held = ch0_code;
    @(negedge clk) ch0_en = 1'b0;
    pulse_trig();
    chk("R8 disabled holds", ch0_code, held);
    chk("R8 disabled no strobe", conv_stb, 0);
    chk("R8 ch1 not updated", ch1_code, 2048);
    ph = (ph + 1) % 16;
    @(negedge clk) ch0_en = 1'b1;
    pulse_trig();
    chk("R8 phase advanced", ch0_code, tab(ph));
    ph = (ph + 1) % 16;
  endtask

  task automatic t_diff();
    @(negedge clk) begin diff_en = 1'b1; ch1_en = 1'b1; end
    for (int n = 0; n < 3; n++) begin
      @(negedge clk) trig = 1'b1;
      tick();
      chk("R6 ch0 sample", ch0_code, tab(ph));
      chk("R6 ch1 inverted", ch1_code, 4095 - tab(ph));
      chk("R6 both strobes", conv_stb, 3);
      ph = (ph + 1) % 16;
      @(negedge clk) trig = 1'b0;
    end
    @(negedge clk) begin free_run = 1'b1; gate_sine = 1'b0; end
    tick();
    chk("R6 ch1 gated mid", ch1_code, 2047);
    chk("R5 ch0 gated mid", ch0_code, 2048);
    ph = 0;
    @(negedge clk) begin diff_en = 1'b0; ch1_en = 1'b0; free_run = 1'b0; end
  endtask

  task automatic t_free(int p);
    int gap;
    @(negedge clk) begin presc = 3'(p); free_run = 1'b1; gate_sine = 1'b0; end
    tick();
    chk("R5 gated mid", ch0_code, 2048);
    @(negedge clk) gate_sine = 1'b1;
    tick();
    chk("R4 first strobe", conv_stb[0], 1);
    chk("R5 first entry 0", ch0_code, tab(0));
    for (int s = 1; s < 4; s++) begin
      gap = 0;
      for (int n = 1; n <= 40; n++) begin
        tick();
        if (conv_stb[0]) begin gap = n; break; end
      end
      chk("R4 sample spacing", gap, 2 * (p + 1));
      chk("R3 free sample", ch0_code, tab(s));
    end
  endtask

  task automatic t_gate();
    @(negedge clk) gate_sine = 1'b0;
    for (int n = 0; n < 5; n++) begin
      tick();
      chk("R5 gated code", ch0_code, 2048);
      chk("R5 gated no strobe", conv_stb, 0);
    end
    @(negedge clk) trig = 1'b1;
    tick();
    chk("R9 trig ignored code", ch0_code, 2048);
    chk("R9 trig ignored strobe", conv_stb, 0);
    @(negedge clk) begin trig = 1'b0; presc = 3'd0; gate_sine = 1'b1; end
    tick();
    chk("R9 phase not moved", ch0_code, tab(0));
    tick();
    tick();
    chk("R5 second sample", ch0_code, tab(1));
  endtask

  task automatic t_driver();
    @(negedge clk) begin free_run = 1'b1; gate_drv = 1'b0; end
    tick();
    chk("R7 driver off", drv_oe, 0);
    @(negedge clk) gate_drv = 1'b1;
    tick();
    chk("R7 driver on", drv_oe, 1);
    @(negedge clk) gate_drv = 1'b0;
    tick();
    chk("R7 driver off again", drv_oe, 0);
    @(negedge clk) free_run = 1'b0;
    tick();
    chk("R7 stepped forces on", drv_oe, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_stepped();
    t_disable();
    t_diff();
    t_free(0);
    t_free(3);
    t_free(7);
    t_gate();
    t_driver();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule